// File: doc/BRIEF.md
# Transmit Carrier and Collision Monitor

This block watches one half-duplex Ethernet transmission at a time and judges it for two faults: loss of carrier and late collision. The transmit side marks the first preamble bit with a start strobe and the last bit with an end strobe. It also marks which cycles carry live bits with a bit-enable level, and it pulses a bit-time tick. The monitor counts bit times from the start strobe to measure the 512-bit slot window. It also keeps a per-frame record of what the carrier and link inputs did. How that record is read depends on the selected port mode.

A collision inside the slot window is handed back as an ordinary collision pulse for the retry engine, and the frame is dropped without a report. A collision after the window raises an abort request so that the current frame is abandoned. The frame is then reported with the late-collision flag and a no-retry indication. A frame that ends normally is reported one cycle after its end strobe, with loss of carrier judged as follows:
- Looped-back serial mode: carrier must arrive before the last bit and then stay up.
- General-purpose serial mode: carrier must appear at some point during the frame.
- Twisted-pair mode: the link-fail input decides.

All flags stay set until a clear pulse arrives or the next transmit start is accepted.

The controller has three states:
- `ST_IDLE` waits for a start strobe (transition T_START to `ST_SEND`).
- `ST_SEND` watches the frame. It leaves on one of three transitions:
  - T_COLL, an in-window collision, goes back to `ST_IDLE`.
  - T_LATE, a late collision, goes to `ST_REPORT`.
  - T_END, the end strobe, goes to `ST_REPORT`.
- `ST_REPORT` posts the verdict for one cycle and takes T_DONE back to `ST_IDLE`.

Top module: `tx_link_watch`

## Requirements
- R1: After reset every output (`lcar_flag`, `lcol_flag`, `abort_req`, `no_retry`, `normal_coll`, `frame_done`) is 0.
- R2: The bit-time count is cleared when a start is accepted and advances by one per sampled `bit_tick` while the frame is active. A collision sampled with a count of 512 or less gives a one-cycle `normal_coll` pulse in the next cycle. That frame then ends with no report: `frame_done` and `lcol_flag` stay 0.
- R3: A collision sampled with a count above 512 gives a one-cycle `abort_req` pulse in the next cycle. One cycle later `lcol_flag`, `no_retry` and `frame_done` are 1 and `lcar_flag` is unchanged. The count saturates, so any count beyond 512 stays late.
- R4: With `port_mode` 0 (looped-back serial), or the spare code 3 which behaves the same, `lcar_flag` is set if `carrier_in` is never 1 in a watched cycle before the cycle that carries `tx_end`.
- R5: In the same modes, `lcar_flag` is also set if `carrier_in` returns to 0 in a watched cycle after having been seen, before the `tx_end` cycle.
- R6: With `port_mode` 1 (general-purpose serial), `lcar_flag` is set only if `carrier_in` is 0 in every watched cycle, the `tx_end` cycle included. Early drops do not matter.
- R7: With `port_mode` 2 (twisted pair), `lcar_flag` is set if and only if `link_fail` is 1 in some watched cycle. `carrier_in` is ignored in this mode.
- R8: A frame that ends normally is reported in the cycle after its `tx_end` is sampled. `frame_done` pulses for one cycle, and a loss of carrier sets `no_retry` together with `lcar_flag`.
- R9: The flags are sticky. They clear on `flag_clear` or on an accepted `tx_start`. When a report sets a flag in the same cycle as `flag_clear`, the report wins.
- R10: A cycle with `tx_en` at 0 is not watched. Its `carrier_in`, `collision_in` and `link_fail` values have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Pulse on the first preamble bit; accepted only when idle |
| tx_en | input | 1 | High in cycles that carry live transmit bits |
| tx_end | input | 1 | Pulse in the cycle of the last frame bit |
| carrier_in | input | 1 | Carrier sense, or receive enable in general-purpose serial mode |
| collision_in | input | 1 | Collision indication |
| port_mode | input | 2 | 0 looped-back serial, 1 general-purpose serial, 2 twisted pair, 3 as 0 |
| link_fail | input | 1 | Twisted-pair link failure status |
| bit_tick | input | 1 | One pulse per network bit time |
| flag_clear | input | 1 | Clears the sticky flags |
| lcar_flag | output | 1 | Loss of carrier seen on the reported frame |
| lcol_flag | output | 1 | Late collision on the reported frame |
| abort_req | output | 1 | One-cycle request to abandon the current frame |
| no_retry | output | 1 | The reported frame must not be retried |
| normal_coll | output | 1 | One-cycle in-window collision for the retry engine |
| frame_done | output | 1 | One-cycle pulse when a frame verdict is posted |

## Verification
The bench builds the block with the default slot length of 512 bit times. This puts collisions at counts 511, 512 and 513 within direct reach, as well as counts far past the saturation point. All four `port_mode` codes are swept against frames of three to six watched cycles, with every carrier window position, so arrival before, at and after the last bit, and early drops, are all covered exhaustively. Directed frames cover link failure, gated cycles with `tx_en` low, and a clear pulse that arrives together with a report.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

    typedef enum logic [1:0] {
        MODE_LOOP  = 2'd0,
        MODE_GPSER = 2'd1,
        MODE_TP    = 2'd2,
        MODE_SPARE = 2'd3
    } port_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_REPORT = 2'd2
    } tx_state_e;

endpackage

// File: rtl/tlw_slot_timer.sv
module tlw_slot_timer #(
    parameter int SLOT_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic late
);
    localparam int CW = $clog2(SLOT_BITS + 2);
    localparam logic [CW-1:0] LIMIT = CW'(SLOT_BITS + 1);
    localparam logic [CW-1:0] EDGE  = CW'(SLOT_BITS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && tick && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign late = (cnt > EDGE);
endmodule

// File: rtl/tlw_carrier_judge.sv
module tlw_carrier_judge
    import tlw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       watch,
    input  logic       last,
    input  logic       carrier,
    input  logic       link_fail,
    input  port_mode_e mode,
    output logic       lcar_fail
);
    logic seen_pre;
    logic seen_any;
    logic dropped;
    logic lf_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_pre <= 1'b0;
            seen_any <= 1'b0;
            dropped  <= 1'b0;
            lf_any   <= 1'b0;
        end else if (start) begin
            seen_pre <= 1'b0;
            seen_any <= 1'b0;
            dropped  <= 1'b0;
            lf_any   <= 1'b0;
        end else if (watch) begin
            if (carrier) seen_any <= 1'b1;
            if (link_fail) lf_any <= 1'b1;
            if (!last) begin
                if (carrier) seen_pre <= 1'b1;
                else if (seen_pre) dropped <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (mode)
            MODE_GPSER: lcar_fail = !seen_any;
            MODE_TP:    lcar_fail = lf_any;
            default:    lcar_fail = !seen_pre || dropped;
        endcase
    end
endmodule

// File: rtl/tlw_ctrl.sv
module tlw_ctrl
    import tlw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_start,
    input  logic tx_en,
    input  logic tx_end,
    input  logic collision,
    input  logic late,
    input  logic lcar_fail,
    input  logic flag_clear,
    output logic start_acc,
    output logic watch,
    output logic running,
    output logic lcar_flag,
    output logic lcol_flag,
    output logic abort_req,
    output logic no_retry,
    output logic normal_coll,
    output logic frame_done
);
    tx_state_e state, state_nx;
    logic aborted;
    logic coll_hit;
    logic set_lcol;
    logic set_lcar;

    assign start_acc = (state == ST_IDLE) && tx_start;
    assign running   = (state == ST_SEND);
    assign watch     = running && tx_en;
    assign coll_hit  = watch && collision;
    assign set_lcol  = (state == ST_REPORT) && aborted;
    assign set_lcar  = (state == ST_REPORT) && !aborted && lcar_fail;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (tx_start) state_nx = ST_SEND;                 // T_START
            ST_SEND: begin
                if (coll_hit && late)  state_nx = ST_REPORT;             // T_LATE
                else if (coll_hit)     state_nx = ST_IDLE;               // T_COLL
                else if (tx_end)       state_nx = ST_REPORT;             // T_END
            end
            ST_REPORT: state_nx = ST_IDLE;                               // T_DONE
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcar_flag   <= 1'b0;
            lcol_flag   <= 1'b0;
            abort_req   <= 1'b0;
            no_retry    <= 1'b0;
            normal_coll <= 1'b0;
            frame_done  <= 1'b0;
            aborted     <= 1'b0;
        end else begin
            normal_coll <= coll_hit && !late;
            abort_req   <= coll_hit && late;
            frame_done  <= (state == ST_REPORT);
            if (coll_hit && late) aborted <= 1'b1;
            else if (start_acc)   aborted <= 1'b0;
            if (set_lcol || set_lcar) begin
                lcol_flag <= lcol_flag || set_lcol;
                lcar_flag <= lcar_flag || set_lcar;
                no_retry  <= 1'b1;
            end else if (flag_clear || start_acc) begin
                lcol_flag <= 1'b0;
                lcar_flag <= 1'b0;
                no_retry  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tx_link_watch.sv
module tx_link_watch
    import tlw_pkg::*;
#(
    parameter int SLOT_BITS = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_start,
    input  logic       tx_en,
    input  logic       tx_end,
    input  logic       carrier_in,
    input  logic       collision_in,
    input  logic [1:0] port_mode,
    input  logic       link_fail,
    input  logic       bit_tick,
    input  logic       flag_clear,
    output logic       lcar_flag,
    output logic       lcol_flag,
    output logic       abort_req,
    output logic       no_retry,
    output logic       normal_coll,
    output logic       frame_done
);
    logic start_acc;
    logic watch;
    logic running;
    logic late;
    logic lcar_fail;

    tlw_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_acc),
        .run   (running),
        .tick  (bit_tick),
        .late  (late)
    );

    tlw_carrier_judge u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_acc),
        .watch     (watch),
        .last      (tx_end),
        .carrier   (carrier_in),
        .link_fail (link_fail),
        .mode      (port_mode_e'(port_mode)),
        .lcar_fail (lcar_fail)
    );

    tlw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_start    (tx_start),
        .tx_en       (tx_en),
        .tx_end      (tx_end),
        .collision   (collision_in),
        .late        (late),
        .lcar_fail   (lcar_fail),
        .flag_clear  (flag_clear),
        .start_acc   (start_acc),
        .watch       (watch),
        .running     (running),
        .lcar_flag   (lcar_flag),
        .lcol_flag   (lcol_flag),
        .abort_req   (abort_req),
        .no_retry    (no_retry),
        .normal_coll (normal_coll),
        .frame_done  (frame_done)
    );
endmodule

// File: rtl/tx_link_watch_chk.sv
module tx_link_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic lcar_flag,
    input logic lcol_flag,
    input logic abort_req,
    input logic no_retry,
    input logic normal_coll,
    input logic frame_done
);
    // R3: abort is a single-cycle request
    a_r3_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req);

    // R3: abort is followed by the late-collision report
    a_r3_abort_report: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (lcol_flag && no_retry && frame_done));

    // R2: in-window and late collisions are exclusive
    a_r2_coll_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        normal_coll |-> !abort_req);

    // R8: loss of carrier forbids retry
    a_r8_lcar_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
        lcar_flag |-> no_retry);

    // R3: late collision forbids retry
    a_r3_lcol_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
        lcol_flag |-> no_retry);

    // R8: loss of carrier is posted only with a frame verdict
    a_r8_lcar_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcar_flag) |-> frame_done);

    // R8: the verdict strobe lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind tx_link_watch tx_link_watch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lcar_flag   (lcar_flag),
    .lcol_flag   (lcol_flag),
    .abort_req   (abort_req),
    .no_retry    (no_retry),
    .normal_coll (normal_coll),
    .frame_done  (frame_done)
);

// File: tb/tx_link_watch_bench.sv
module tx_link_watch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_start = 0, tx_en = 0, tx_end = 0, carrier_in = 0, collision_in = 0;
    logic [1:0] port_mode = 2'd0;
    logic link_fail = 0, bit_tick = 0, flag_clear = 0;
    logic lcar_flag, lcol_flag, abort_req, no_retry, normal_coll, frame_done;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_link_watch #(.SLOT_BITS(SLOT)) u_tx_link_watch (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_en(tx_en),
        .tx_end(tx_end), .carrier_in(carrier_in), .collision_in(collision_in),
        .port_mode(port_mode), .link_fail(link_fail), .bit_tick(bit_tick),
        .flag_clear(flag_clear), .lcar_flag(lcar_flag), .lcol_flag(lcol_flag),
        .abort_req(abort_req), .no_retry(no_retry), .normal_coll(normal_coll),
        .frame_done(frame_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        tx_start = 0; tx_en = 0; tx_end = 0; carrier_in = 0;
        collision_in = 0; link_fail = 0; bit_tick = 0; flag_clear = 0;
    endtask

    task automatic begin_frame();
        @(negedge clk);
        quiet();
        tx_start = 1;
        @(negedge clk);
        tx_start = 0;
    endtask

    // watched cycles 0..len-1, tx_end on the last; carrier high in [c_on, c_off)
    task automatic run_frame(input int mode, input int len, input int c_on,
                             input int c_off, input bit lf, input bit clr_at_report);
        port_mode = 2'(mode);
        begin_frame();
        for (int i = 0; i < len; i++) begin
            tx_en = 1;
            carrier_in = (i >= c_on) && (i < c_off);
            link_fail = lf;
            tx_end = (i == len - 1);
            @(negedge clk);
        end
        quiet();
        flag_clear = clr_at_report;
        @(negedge clk);
        flag_clear = 0;
    endtask

    task automatic coll_test(input int n);
        int late;
        late = (n > SLOT) ? 1 : 0;
        port_mode = 2'd0;
        begin_frame();
        tx_en = 1; carrier_in = 1;
        for (int i = 0; i < n; i++) begin
            bit_tick = 1;
            @(negedge clk);
        end
        bit_tick = 0;
        collision_in = 1;
        @(negedge clk);
        collision_in = 0;
        chk($sformatf("R3 abort_req n=%0d", n), abort_req, late);
        chk($sformatf("R2 normal_coll n=%0d", n), normal_coll, 1 - late);
        if (late == 0) begin
            quiet();
            @(negedge clk);
            chk($sformatf("R2 no report n=%0d", n), frame_done, 0);
            chk($sformatf("R2 lcol n=%0d", n), lcol_flag, 0);
        end else begin
            tx_end = 1;
            @(negedge clk);
            quiet();
            chk($sformatf("R3 abort pulse n=%0d", n), abort_req, 0);
            chk($sformatf("R3 lcol n=%0d", n), lcol_flag, 1);
            chk($sformatf("R3 no_retry n=%0d", n), no_retry, 1);
            chk($sformatf("R3 frame_done n=%0d", n), frame_done, 1);
            chk($sformatf("R3 lcar n=%0d", n), lcar_flag, 0);
            @(negedge clk);
        end
        quiet();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 lcar", lcar_flag, 0);
        chk("R1 lcol", lcol_flag, 0);
        chk("R1 abort", abort_req, 0);
        chk("R1 no_retry", no_retry, 0);
        chk("R1 normal_coll", normal_coll, 0);
        chk("R1 frame_done", frame_done, 0);
        rst_n = 1;
        @(negedge clk);

        // exhaustive carrier sweep over all modes and short frames
        for (int mode = 0; mode < 4; mode++) begin
            for (int len = 3; len <= 6; len++) begin
                for (int c_on = 0; c_on <= len; c_on++) begin
                    for (int c_off = c_on; c_off <= len + 1; c_off++) begin
                        bit lf;
                        bit has_pre, dropped, any, exp_fail;
                        string tag;
                        lf = ((c_on + c_off + len) % 2) == 1;
                        has_pre = (c_on < c_off) && (c_on < len - 1);
                        dropped = has_pre && (c_off < len - 1);
                        any     = (c_on < c_off) && (c_on < len);
                        if (mode == 1) begin
                            exp_fail = !any; tag = "R6 gpser lcar";
                        end else if (mode == 2) begin
                            exp_fail = lf; tag = "R7 tp lcar";
                        end else begin
                            exp_fail = !has_pre || dropped;
                            tag = dropped ? "R5 loop drop lcar" : "R4 loop lcar";
                        end
                        run_frame(mode, len, c_on, c_off, lf, 1'b0);
                        tag = $sformatf("%s m=%0d len=%0d on=%0d off=%0d",
                                        tag, mode, len, c_on, c_off);
                        chk(tag, lcar_flag, exp_fail);
                        chk({"R8 no_retry ", tag}, no_retry, exp_fail);
                        chk({"R8 frame_done ", tag}, frame_done, 1);
                        chk({"R3 lcol clear ", tag}, lcol_flag, 0);
                    end
                end
            end
        end

        // slot window boundaries and saturation
        coll_test(0);
        coll_test(1);
        coll_test(511);
        coll_test(512);
        coll_test(513);
        coll_test(514);
        coll_test(1030);

        // R9: sticky, report beats a simultaneous clear, then clear and start clear it
        run_frame(0, 4, 0, 0, 1'b0, 1'b1);
        chk("R9 report wins over clear", lcar_flag, 1);
        repeat (5) @(negedge clk);
        chk("R9 sticky lcar", lcar_flag, 1);
        chk("R9 sticky no_retry", no_retry, 1);
        flag_clear = 1;
        @(negedge clk);
        flag_clear = 0;
        chk("R9 clear lcar", lcar_flag, 0);
        chk("R9 clear no_retry", no_retry, 0);
        run_frame(1, 4, 0, 0, 1'b0, 1'b0);
        chk("R9 set again", lcar_flag, 1);
        @(negedge clk);
        tx_start = 1;
        @(negedge clk);
        tx_start = 0;
        chk("R9 start clears lcar", lcar_flag, 0);
        // finish the started frame cleanly with carrier
        tx_en = 1; carrier_in = 1; tx_end = 1;
        @(negedge clk);
        quiet();
        @(negedge clk);
        chk("R9 clean frame", lcar_flag, 0);

        // R10: gated cycle hides a carrier drop
        port_mode = 2'd0;
        begin_frame();
        for (int i = 0; i < 6; i++) begin
            tx_en = (i != 2);
            carrier_in = (i != 2);
            tx_end = (i == 5);
            @(negedge clk);
        end
        quiet();
        @(negedge clk);
        chk("R10 gated drop ignored", lcar_flag, 0);

        // R10: gated link_fail in twisted-pair mode
        port_mode = 2'd2;
        begin_frame();
        for (int i = 0; i < 4; i++) begin
            tx_en = (i != 1);
            link_fail = (i == 1);
            tx_end = (i == 3);
            @(negedge clk);
        end
        quiet();
        @(negedge clk);
        chk("R10 gated link_fail ignored", lcar_flag, 0);

        // R10: gated late collision
        port_mode = 2'd0;
        begin_frame();
        tx_en = 1; carrier_in = 1;
        for (int i = 0; i < 600; i++) begin
            bit_tick = 1;
            @(negedge clk);
        end
        bit_tick = 0;
        tx_en = 0; collision_in = 1;
        @(negedge clk);
        chk("R10 gated collision abort", abort_req, 0);
        chk("R10 gated collision normal", normal_coll, 0);
        collision_in = 0; tx_en = 1; tx_end = 1;
        @(negedge clk);
        quiet();
        @(negedge clk);
        chk("R10 gated collision lcol", lcol_flag, 0);
        chk("R10 gated collision done", frame_done, 1);
        chk("R10 gated collision lcar", lcar_flag, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule